// File: doc/BRIEF.md
# Register-range stack transfer sequencer

This block carries out four block-transfer commands that save or restore a contiguous range of general registers on a stack that grows toward lower addresses. R15 holds the stack pointer. A command is a 16-bit instruction word presented with a valid strobe while the block is idle. The block reads R15 once and keeps the moving pointer in an internal register. It then moves one 32-bit word per register through a request/ready memory port, and writes the final pointer back into R15 as its last action.

Two variants cover the low range, from R0 up to a chosen register Rn. The other two cover the high range, from Rn up to R14 plus the procedure-return register PR. Slot number 15 always means PR, never R15. Pushes walk the slots downward and decrement the pointer before each store. Pops walk upward and increment it after each load. A push followed by the matching pop therefore leaves the registers and R15 as they were. The register file is reached through one shared port: reads are combinational and writes are clocked.

Top module: `regstack_seq`

## Requirements
- R1: A command starts only when the word matches 0100_nnnn_1111_0x0y, where bit 2 = 1 selects pop, bit 0 = 1 selects the low range, and bits 11:8 give n. Any other word leaves busy low and produces no memory request.
- R2: Low-range push (low byte 0xF1) stores slots n, n-1, ... 0, in that order. Each store goes to the pointer minus 4, and that value becomes the new pointer.
- R3: Low-range pop (low byte 0xF5) loads slots 0, 1, ... n, in that order. Each load comes from the current pointer, and the pointer then advances by 4.
- R4: High-range push (low byte 0xF0) stores PR first, then R14 down to Rn, with the same predecrement rule as R2.
- R5: High-range pop (low byte 0xF4) loads Rn up to R14 and PR last, with the same postincrement rule as R3.
- R6: Slot 15 maps to PR (register-port address 16). With n = 15, the low range moves PR and R0..R14, and the high range moves PR alone. R15 is never moved to or from memory.
- R7: Each transferred register costs exactly one accepted memory access. R15 is written once, after the last access, with the initial value minus or plus 4 times the transfer count.
- R8: busy rises the cycle after a command is accepted and stays high until the R15 write-back. done is a one-cycle pulse in the first cycle after busy falls. The busy time is 2 + N*(wait+1) cycles for a pop and 2 + N*(wait+2) cycles for a push.
- R9: While a request waits for ready, mem_req, mem_we, mem_addr and mem_wdata hold their values.
- R10: Commands presented while busy is high are ignored.
- R11: A push followed by the pop with the same range restores every register in that range and R15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command word is present |
| cmd_insn | input | 16 | Instruction word to decode |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| rf_addr | output | 5 | Register port address: 0..15 general, 16 = PR |
| rf_we | output | 1 | Register port write enable |
| rf_wdata | output | 32 | Register port write data |
| rf_rdata | input | 32 | Register port read data (combinational) |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | 32 | Word address of the access |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with mem_ready |
| mem_ready | input | 1 | Access accepted this cycle |

## Verification
The hardest case to reach is a new command arriving while a long sequence is stalled on memory. The ignore rule, the request hold and the single R15 write-back all meet in that case. The stimulus holds ready low for several cycles on every access. It keeps a different, valid push word asserted on the command input for the whole busy period and drops it in the cycle where busy has just fallen. The n = 15 encodings are driven for all four variants, so the PR remapping is seen at both range ends and in both directions.

// File: rtl/regstack_pkg.sv
// Shared constants and types for the register-range stack sequencer.
// Assumes a 32-entry-addressable register port where 0..15 are general
// registers and 16 selects PR.
package regstack_pkg;
    localparam int RF_AW = 5;
    localparam int SLOT_W = 4;
    localparam logic [RF_AW-1:0] SP_IDX = 5'd15;
    localparam logic [RF_AW-1:0] PR_IDX = 5'd16;
    localparam logic [SLOT_W-1:0] SLOT_TOP = 4'hF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LDSP,
        ST_FETCH,
        ST_XFER,
        ST_STSP
    } seq_state_t;

    typedef struct packed {
        logic              push;
        logic [SLOT_W-1:0] first;
        logic [SLOT_W-1:0] last;
    } xfer_plan_t;
endpackage

// File: rtl/regstack_decode.sv
// Command decoder: recognises the four transfer words and produces the
// first slot, last slot and direction. Purely combinational.
module regstack_decode
    import regstack_pkg::*;
(
    input  logic [15:0] insn,
    output logic        hit,
    output xfer_plan_t  plan
);
    logic [SLOT_W-1:0] sel;
    logic              is_pop;
    logic              is_low;

    // decode fields and range ends
    always_comb begin
        sel    = insn[11:8];
        is_pop = insn[2];
        is_low = insn[0];
        hit    = (insn[15:12] == 4'b0100) && (insn[7:3] == 5'b11110) && !insn[1];
        plan.push = !is_pop;
        case ({is_pop, is_low})
            2'b01:   begin plan.first = sel;      plan.last = '0;       end
            2'b11:   begin plan.first = '0;       plan.last = sel;      end
            2'b00:   begin plan.first = SLOT_TOP; plan.last = sel;      end
            default: begin plan.first = sel;      plan.last = SLOT_TOP; end
        endcase
    end
endmodule

// File: rtl/regstack_slot.sv
// Slot walker: holds the current slot, steps it down for pushes and up
// for pops, and flags the final slot. Assumes first/last are ordered for
// the direction given at load time.
module regstack_slot
    import regstack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [SLOT_W-1:0] first,
    input  logic [SLOT_W-1:0] last,
    input  logic              down,
    input  logic              step,
    output logic [SLOT_W-1:0] cur,
    output logic              at_last
);
    logic [SLOT_W-1:0] last_q;
    logic              down_q;

    // current slot, end slot and direction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur    <= '0;
            last_q <= '0;
            down_q <= 1'b0;
        end else if (load) begin
            cur    <= first;
            last_q <= last;
            down_q <= down;
        end else if (step) begin
            cur <= down_q ? cur - 1'b1 : cur + 1'b1;
        end
    end

    assign at_last = (cur == last_q);
endmodule

// File: rtl/regstack_sp.sv
// Stack pointer shadow: loaded from R15 once, then stepped by one word
// per transfer. Also offers the predecremented address for stores.
module regstack_sp #(
    parameter int XLEN = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [XLEN-1:0] load_val,
    input  logic            step,
    input  logic            down,
    output logic [XLEN-1:0] sp_q,
    output logic [XLEN-1:0] sp_dn
);
    localparam logic [XLEN-1:0] STEP = XLEN'(XLEN / 8);

    // pointer register
    always_ff @(posedge clk) begin
        if (!rst_n)
            sp_q <= '0;
        else if (load)
            sp_q <= load_val;
        else if (step)
            sp_q <= down ? sp_q - STEP : sp_q + STEP;
    end

    assign sp_dn = sp_q - STEP;
endmodule

// File: rtl/regstack_seq.sv
// Register-range stack transfer sequencer (top).
// Accepts a transfer word while idle, reads R15, moves one word per slot
// through the memory port (slot 15 = PR), then writes R15 back once.
// Assumes rf_rdata is a combinational read of rf_addr and that mem_rdata
// is valid in the cycle mem_ready is high.
module regstack_seq
    import regstack_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [15:0]      cmd_insn,
    output logic             busy,
    output logic             done,
    output logic [RF_AW-1:0] rf_addr,
    output logic             rf_we,
    output logic [XLEN-1:0]  rf_wdata,
    input  logic [XLEN-1:0]  rf_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [XLEN-1:0]  mem_addr,
    output logic [XLEN-1:0]  mem_wdata,
    input  logic [XLEN-1:0]  mem_rdata,
    input  logic             mem_ready
);
    seq_state_t        state_q, state_d;
    xfer_plan_t        dec_plan;
    logic              dec_hit;
    logic              accept;
    logic              beat;
    logic              push_q;
    logic              done_q;
    logic [XLEN-1:0]   data_q;
    logic [SLOT_W-1:0] cur_slot;
    logic              at_last;
    logic [RF_AW-1:0]  slot_rf;
    logic [XLEN-1:0]   sp_q, sp_dn;

    regstack_decode u_dec (
        .insn (cmd_insn),
        .hit  (dec_hit),
        .plan (dec_plan)
    );

    assign accept = (state_q == ST_IDLE) && cmd_valid && dec_hit;
    assign beat   = (state_q == ST_XFER) && mem_ready;

    regstack_slot u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .first   (dec_plan.first),
        .last    (dec_plan.last),
        .down    (dec_plan.push),
        .step    (beat),
        .cur     (cur_slot),
        .at_last (at_last)
    );

    regstack_sp #(.XLEN(XLEN)) u_sp (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state_q == ST_LDSP),
        .load_val (rf_rdata),
        .step     (beat),
        .down     (push_q),
        .sp_q     (sp_q),
        .sp_dn    (sp_dn)
    );

    // slot 15 stands for PR on the register port
    assign slot_rf = (cur_slot == SLOT_TOP) ? PR_IDX : {1'b0, cur_slot};

    // state, direction, store data and done pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            push_q  <= 1'b0;
            data_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            done_q  <= (state_q == ST_STSP);
            if (accept)
                push_q <= dec_plan.push;
            if (state_q == ST_FETCH)
                data_q <= rf_rdata;
        end
    end

    // next state and port drive per state
    always_comb begin
        state_d   = state_q;
        rf_addr   = '0;
        rf_we     = 1'b0;
        rf_wdata  = '0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = '0;
        case (state_q)
            ST_IDLE: begin
                if (accept)
                    state_d = ST_LDSP;
            end
            ST_LDSP: begin
                rf_addr = SP_IDX;
                state_d = push_q ? ST_FETCH : ST_XFER;
            end
            ST_FETCH: begin
                rf_addr = slot_rf;
                state_d = ST_XFER;
            end
            ST_XFER: begin
                mem_req   = 1'b1;
                mem_we    = push_q;
                mem_addr  = push_q ? sp_dn : sp_q;
                mem_wdata = data_q;
                if (!push_q) begin
                    rf_addr  = slot_rf;
                    rf_we    = mem_ready;
                    rf_wdata = mem_rdata;
                end
                if (mem_ready)
                    state_d = at_last ? ST_STSP : (push_q ? ST_FETCH : ST_XFER);
            end
            ST_STSP: begin
                rf_we    = 1'b1;
                rf_addr  = SP_IDX;
                rf_wdata = sp_q;
                state_d  = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign busy = (state_q != ST_IDLE);
    assign done = done_q;
endmodule

// File: rtl/regstack_seq_chk.sv
// Protocol checker for regstack_seq, attached through bind.
// Observes ports only; assumes synchronous active-low reset.
module regstack_seq_chk #(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic            busy,
    input logic            done,
    input logic [4:0]      rf_addr,
    input logic            rf_we,
    input logic            mem_req,
    input logic            mem_we,
    input logic [XLEN-1:0] mem_addr,
    input logic [XLEN-1:0] mem_wdata,
    input logic            mem_ready
);
    // R9
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_we) && $stable(mem_addr) && $stable(mem_wdata));

    // R8
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8
    req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);

    // R7
    sp_write_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we && rf_addr == 5'd15 |=> !busy && done);

    // R6
    rf_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rf_we |-> rf_addr <= 5'd16);

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !cmd_valid |=> !busy);
endmodule

bind regstack_seq regstack_seq_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .done      (done),
    .rf_addr   (rf_addr),
    .rf_we     (rf_we),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_ready (mem_ready)
);

// File: tb/test_regstack_seq.sv
`timescale 1ns/1ps
module test_regstack_seq;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [15:0] cmd_insn;
    logic        busy, done;
    logic [4:0]  rf_addr;
    logic        rf_we;
    logic [31:0] rf_wdata, rf_rdata;
    logic        mem_req, mem_we, mem_ready;
    logic [31:0] mem_addr, mem_wdata, mem_rdata;

    logic        poke_en;
    logic [4:0]  poke_idx;
    logic [31:0] poke_val;

    logic [31:0] rf_m  [0:16];
    logic [31:0] mem_m [0:255];

    int compared = 0;
    int mismatched = 0;

    always #2 clk = ~clk;

    regstack_seq i_regstack_seq (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_insn(cmd_insn),
        .busy(busy), .done(done), .rf_addr(rf_addr), .rf_we(rf_we),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    // environment: register file and memory models
    assign rf_rdata  = rf_m[rf_addr];
    assign mem_rdata = mem_m[mem_addr[9:2]];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 17; i++)
                rf_m[i] <= (i == 15) ? 32'h0000_0200 : 32'h5000_0000 + 32'(i) * 32'h0101_0101;
            for (int i = 0; i < 256; i++)
                mem_m[i] <= 32'hC0DE_0000 + 32'(i);
        end else begin
            if (rf_we) rf_m[rf_addr] <= rf_wdata;
            else if (poke_en) rf_m[poke_idx] <= poke_val;
            if (mem_req && mem_ready && mem_we) mem_m[mem_addr[9:2]] <= mem_wdata;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic poke(input int idx, input logic [31:0] val);
        @(negedge clk);
        poke_en = 1'b1; poke_idx = 5'(idx); poke_val = val;
        @(negedge clk);
        poke_en = 1'b0;
    endtask

    task automatic probe(input logic [15:0] insn);
        bit ok = 1;
        logic [31:0] sp0 = rf_m[15];
        @(negedge clk);
        cmd_valid = 1'b1; cmd_insn = insn;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            if (busy !== 1'b0 || mem_req !== 1'b0) ok = 0;
        end
        cmd_valid = 1'b0;
        check(ok, "R1", "unknown word started a sequence", {31'd0, busy}, 32'd0);
        check(rf_m[15] === sp0, "R1", "R15 after unknown word", rf_m[15], sp0);
    endtask

    // reference model: expected access list, busy time and final registers
    task automatic run_cmd(input logic [15:0] insn, input int wt, input bit noisy, input string tag);
        int          slots[$];
        bit          exp_we[$];
        logic [31:0] exp_addr[$];
        logic [31:0] exp_data[$];
        logic [31:0] exp_rf [0:16];
        logic [31:0] sp;
        int          n = int'(insn[11:8]);
        bit          lo = insn[0];
        bit          pop = insn[2];
        int          nb = 0;
        int          acc = 0;
        int          cnt = 0;
        int          tlim;
        bit          stable_ok = 1;
        bit          prev_wait = 0;
        logic [31:0] prev_addr = '0;
        bit          ok = 1;
        for (int i = 0; i < 17; i++) exp_rf[i] = rf_m[i];
        sp = rf_m[15];
        if (pop) begin
            if (lo) for (int s = 0; s <= n; s++) slots.push_back(s);
            else    for (int s = n; s <= 15; s++) slots.push_back(s);
        end else begin
            if (lo) for (int s = n; s >= 0; s--) slots.push_back(s);
            else    for (int s = 15; s >= n; s--) slots.push_back(s);
        end
        foreach (slots[k]) begin
            int r = (slots[k] == 15) ? 16 : slots[k];
            if (pop) begin
                exp_we.push_back(1'b0);
                exp_addr.push_back(sp);
                exp_rf[r] = mem_m[sp[9:2]];
                exp_data.push_back(exp_rf[r]);
                sp += 32'd4;
            end else begin
                sp -= 32'd4;
                exp_we.push_back(1'b1);
                exp_addr.push_back(sp);
                exp_data.push_back(rf_m[r]);
            end
        end
        exp_rf[15] = sp;
        tlim = 2 + slots.size() * (wt + 1) + (pop ? 0 : slots.size());

        @(negedge clk);
        cmd_valid = 1'b1; cmd_insn = insn;
        @(negedge clk);
        if (noisy) cmd_insn = 16'h4FF1;   // R10: valid word held during busy
        else cmd_valid = 1'b0;
        for (int g = 0; g < 4000 && busy; g++) begin
            nb++;
            if (prev_wait && (mem_req !== 1'b1 || mem_addr !== prev_addr)) stable_ok = 0;
            mem_ready = 1'b0;
            if (mem_req) begin
                if (cnt == wt) begin
                    if (acc < exp_addr.size())
                        check(mem_we === exp_we[acc] && mem_addr === exp_addr[acc] &&
                              (!exp_we[acc] || mem_wdata === exp_data[acc]),
                              tag, "access order/address/data", mem_addr, exp_addr[acc]);
                    else
                        check(0, tag, "extra access", mem_addr, 32'd0);
                    acc++; mem_ready = 1'b1; cnt = 0; prev_wait = 0;
                end else begin
                    cnt++; prev_wait = 1; prev_addr = mem_addr;
                end
            end else prev_wait = 0;
            @(negedge clk);
        end
        mem_ready = 1'b0;
        cmd_valid = 1'b0;
        check(nb == tlim, "R8", "busy cycles", 32'(nb), 32'(tlim));
        check(done === 1'b1, "R8", "done after busy", {31'd0, done}, 32'd1);
        check(acc == slots.size(), "R7", "access count", 32'(acc), 32'(slots.size()));
        if (wt > 0) check(stable_ok, "R9", "request held while waiting", {31'd0, stable_ok}, 32'd1);
        @(negedge clk);
        check(done === 1'b0, "R8", "done single cycle", {31'd0, done}, 32'd0);
        check(rf_m[15] === exp_rf[15], "R7", "final R15", rf_m[15], exp_rf[15]);
        for (int i = 0; i < 17; i++) if (rf_m[i] !== exp_rf[i]) ok = 0;
        check(ok, tag, "register file after command", rf_m[0], exp_rf[0]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        mismatched++;
        compared++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        logic [31:0] snap [0:16];
        bit ok;
        cmd_valid = 1'b0; cmd_insn = '0; mem_ready = 1'b0;
        poke_en = 1'b0; poke_idx = '0; poke_val = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && done === 1'b0, "R8", "reset busy/done", {30'd0, busy, done}, 32'd0);
        check(mem_req === 1'b0 && rf_we === 1'b0, "R8", "reset port idle", {30'd0, mem_req, rf_we}, 32'd0);

        probe(16'h4F02);
        probe(16'h5AF1);
        probe(16'h4FF9);

        for (int i = 0; i < 17; i++) snap[i] = rf_m[i];
        run_cmd(16'h43F1, 0, 0, "R2");
        for (int i = 0; i < 4; i++) poke(i, 32'hDEAD_0000 + 32'(i));
        run_cmd(16'h43F5, 2, 0, "R3");
        ok = 1;
        for (int i = 0; i < 4; i++) if (rf_m[i] !== snap[i]) ok = 0;
        check(ok && rf_m[15] === snap[15], "R11", "push/pop round trip", rf_m[15], snap[15]);

        run_cmd(16'h4CF0, 1, 0, "R4");
        run_cmd(16'h4CF4, 0, 0, "R5");
        run_cmd(16'h4FF1, 0, 0, "R6");
        run_cmd(16'h4FF5, 1, 0, "R6");
        run_cmd(16'h4FF0, 0, 0, "R6");
        run_cmd(16'h4FF4, 0, 0, "R6");
        run_cmd(16'h40F1, 0, 0, "R2");
        run_cmd(16'h40F4, 0, 0, "R5");
        run_cmd(16'h45F0, 3, 1, "R10");
        run_cmd(16'h45F4, 3, 0, "R9");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule